// File: doc/BRIEF.md
# FIFO Threshold Flag Generator

This block produces the level flags of a 512-word FIFO in the write-clock domain. It takes the current word count, which comes from pointer arithmetic with the read pointer already synchronized into this domain. From that count it drives two flags. The first is a half-full flag. The second is a single "near a boundary" flag that is high when the FIFO is close to empty or close to full.

The two boundaries come from two 8-bit offsets: an empty-side offset X and a full-side offset Y. Both default to 64. They can be reloaded from the low byte of the write data while an active-low program strobe is held. This is only possible between reset and the first word stored.

- The first strobed edge loads the byte into both offsets.
- Each further consecutive strobed edge reloads the full-side offset alone.

While an offset load takes place, the block raises a write-inhibit output so that the FIFO storage ignores the write enables in that cycle.

Top module: `fifo_level_flags`

## Requirements
- R1: While reset is low and immediately after it, half_full is 0, near_edge is 1 and wr_inhibit is 0. Both offsets return to 64 and the programming window reopens.
- R2: half_full is registered: after each rising edge it equals (level >= 256) for the level present at that edge.
- R3: near_edge is registered: after each rising edge it equals (level <= X) or (level >= 512 - Y), using the X and Y held before that edge.
- R4: Without any programming, X = Y = 64. near_edge is therefore 1 at levels 64 and 448 and 0 at levels 65 and 447.
- R5: A program edge is a rising edge with prog_n = 0, wr_ready = 1 and the window still open. The first program edge after prog_n was high loads prog_data[7:0] into both X and Y, and the full range 0..255 is honoured.
- R6: wr_inhibit is 1 exactly while a program edge is pending. A write request seen in such a cycle does not count as the first stored word, so the window stays open.
- R7: A second consecutive program edge loads prog_data[7:0] into Y only and leaves X unchanged.
- R8: Every later consecutive program edge also reloads Y only. A cycle with prog_n = 1 restarts the sequence, so the next program edge loads both offsets again.
- R9: A rising edge with wr_en = 1, wr_ready = 1 and wr_inhibit = 0 closes the window until the next reset. After that, prog_n = 0 changes no offset and wr_inhibit stays 0.
- R10: An edge with prog_n = 0 while wr_ready = 0 changes no offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_n | input | 1 | Active-low offset load strobe |
| prog_data | input | 8 | Low data byte carrying the offset value |
| wr_ready | input | 1 | FIFO not full (input-ready state) |
| wr_en | input | 1 | Combined write-enable request |
| level | input | 10 | Current word count, 0..512 |
| half_full | output | 1 | Registered level >= 256 |
| near_edge | output | 1 | Registered almost-empty or almost-full |
| wr_inhibit | output | 1 | Suppresses the storage write during an offset load |

## Verification
An offset load and a write request can land on the same clock edge. The bench provokes this by holding prog_n low with wr_en high and wr_ready high. It judges the outcome in three ways: wr_inhibit must be high in that cycle, the byte must still load both offsets, and a later strobe must still program the offsets, which shows that the window stayed open. A scoreboard fed by the driving task predicts both flags at threshold boundaries just inside and just outside each offset, so every offset change is judged at the ports.

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
  parameter int DEPTH       = 512,
  parameter int OFS_W       = 8,
  parameter int OFS_DEFAULT = 64,
  parameter int CNT_W       = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_n,
  input  logic [OFS_W-1:0] prog_data,
  input  logic             wr_ready,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] level,
  output logic             half_full,
  output logic             near_edge,
  output logic             wr_inhibit
);
  localparam logic [CNT_W-1:0] HALF_LVL = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic [OFS_W-1:0] x_ofs, y_ofs;
  logic             closed;
  logic             repeat_edge;
  logic             armed;
  logic             prog_act;

  assign prog_act   = !prog_n && wr_ready && !closed;
  assign wr_inhibit = prog_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_ofs       <= OFS_W'(OFS_DEFAULT);
      y_ofs       <= OFS_W'(OFS_DEFAULT);
      repeat_edge <= 1'b0;
      closed      <= 1'b0;
    end else begin
      if (prog_act) begin
        y_ofs <= prog_data;
        if (!repeat_edge) x_ofs <= prog_data;
      end
      if (prog_n)        repeat_edge <= 1'b0;
      else if (prog_act) repeat_edge <= 1'b1;
      if (wr_en && wr_ready && !prog_act) closed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_full <= 1'b0;
      near_edge <= 1'b1;
      armed     <= 1'b0;
    end else begin
      half_full <= level >= HALF_LVL;
      near_edge <= (level <= CNT_W'(x_ofs)) || (level >= FULL_LVL - CNT_W'(y_ofs));
      armed     <= 1'b1;
    end
  end

  // R3: flag agrees with the previous level and offsets
  a_r3_near_edge: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> near_edge == (($past(level) <= CNT_W'($past(x_ofs))) ||
                            ($past(level) >= FULL_LVL - CNT_W'($past(y_ofs)))));
  // R2
  a_r2_half_full: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> half_full == ($past(level) >= HALF_LVL));
  // R6: inhibited write never closes the window
  a_r6_inhibit_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
    wr_inhibit |=> !closed);
  // R7: repeated edge leaves X alone
  a_r7_second_edge_y_only: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_act && repeat_edge) |=> $stable(x_ofs));
  // R9: offsets frozen once a word was stored
  a_r9_window_closed: assert property (@(posedge clk) disable iff (!rst_n)
    closed |=> ($stable(x_ofs) && $stable(y_ofs) && !wr_inhibit));
  // R10: no load without input-ready
  a_r10_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> ($stable(x_ofs) && $stable(y_ofs)));
endmodule

// File: tb/fifo_level_flags_tb.sv
module fifo_level_flags_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_n = 1'b1;
  logic [7:0] prog_data = '0;
  logic       wr_ready = 1'b0;
  logic       wr_en = 1'b0;
  logic [9:0] level = '0;
  logic       half_full, near_edge, wr_inhibit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_x, m_y;
  bit m_closed, m_rep;

  bit    q_half[$];
  bit    q_near[$];
  string q_tag[$];

  always #5 clk = ~clk;

  fifo_level_flags u_dut (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .prog_data(prog_data),
    .wr_ready(wr_ready), .wr_en(wr_en), .level(level),
    .half_full(half_full), .near_edge(near_edge), .wr_inhibit(wr_inhibit)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit pn, input int d, input bit we, input bit rdy,
                      input int lv, input string tag);
    bit pa;
    @(negedge clk);
    prog_n = pn; prog_data = 8'(d); wr_en = we; wr_ready = rdy; level = 10'(lv);
    #1;
    pa = !pn && rdy && !m_closed;
    chk(wr_inhibit === pa, {tag, " R6 inhibit"}, int'(wr_inhibit), int'(pa));
    q_half.push_back(lv >= 256);
    q_near.push_back((lv <= m_x) || (lv >= 512 - m_y));
    q_tag.push_back(tag);
    if (pa) begin
      m_y = d;
      if (!m_rep) m_x = d;
    end
    if (pn) m_rep = 0; else if (pa) m_rep = 1;
    if (we && rdy && !pa) m_closed = 1;
  endtask

  always @(negedge clk) begin
    if (q_tag.size() > 0) begin
      bit eh, en;
      string t;
      eh = q_half.pop_front();
      en = q_near.pop_front();
      t  = q_tag.pop_front();
      chk(half_full === eh, {t, " half_full"}, int'(half_full), int'(eh));
      chk(near_edge === en, {t, " near_edge"}, int'(near_edge), int'(en));
    end
  end

  task automatic do_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b0; prog_n = 1'b1; wr_en = 1'b0; level = '0;
    m_x = 64; m_y = 64; m_closed = 0; m_rep = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(half_full === 1'b0, "R1 half_full in reset", int'(half_full), 0);
    chk(near_edge === 1'b1, "R1 near_edge in reset", int'(near_edge), 1);
    chk(wr_inhibit === 1'b0, "R1 wr_inhibit in reset", int'(wr_inhibit), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R4 defaults, R2 half boundary
    step(1, 0, 0, 1, 64,  "R4");
    step(1, 0, 0, 1, 65,  "R4");
    step(1, 0, 0, 1, 447, "R4");
    step(1, 0, 0, 1, 448, "R4");
    step(1, 0, 0, 1, 255, "R2");
    step(1, 0, 0, 1, 256, "R2");
    step(1, 0, 0, 1, 512, "R2");
    // R5 single load
    step(0, 10, 0, 1, 0,   "R5");
    step(1, 0,  0, 1, 10,  "R5");
    step(1, 0,  0, 1, 11,  "R5");
    step(1, 0,  0, 1, 502, "R5");
    step(1, 0,  0, 1, 501, "R5");
    // R7 two-edge sequence
    step(0, 20, 0, 1, 0,   "R7");
    step(0, 30, 0, 1, 0,   "R7");
    step(1, 0,  0, 1, 20,  "R7");
    step(1, 0,  0, 1, 21,  "R7");
    step(1, 0,  0, 1, 482, "R7");
    step(1, 0,  0, 1, 481, "R7");
    // R8 three edges, then restart
    step(0, 50, 0, 1, 0,   "R8");
    step(0, 60, 0, 1, 0,   "R8");
    step(0, 70, 0, 1, 0,   "R8");
    step(1, 0,  0, 1, 50,  "R8");
    step(1, 0,  0, 1, 51,  "R8");
    step(1, 0,  0, 1, 442, "R8");
    step(1, 0,  0, 1, 441, "R8");
    step(0, 5,  0, 1, 0,   "R8");
    step(1, 0,  0, 1, 5,   "R8");
    step(1, 0,  0, 1, 507, "R8");
    step(1, 0,  0, 1, 506, "R8");
    // R10 strobe without input-ready
    step(0, 99, 0, 0, 0,   "R10");
    step(1, 0,  0, 1, 5,   "R10");
    step(1, 0,  0, 1, 6,   "R10");
    // R5 largest offset
    step(0, 255, 0, 1, 0,  "R5");
    step(1, 0,   0, 1, 255, "R5");
    step(1, 0,   0, 1, 256, "R5");
    step(1, 0,   0, 1, 257, "R5");
    // R6 load and write request on the same edge
    step(0, 33, 1, 1, 0,   "R6");
    step(1, 0,  0, 1, 33,  "R6");
    step(1, 0,  0, 1, 34,  "R6");
    step(0, 44, 0, 1, 0,   "R6");
    step(1, 0,  0, 1, 44,  "R6");
    step(1, 0,  0, 1, 45,  "R6");
    // R9 first stored word closes window
    step(1, 0,   1, 1, 0,   "R9");
    step(0, 100, 0, 1, 0,   "R9");
    step(1, 0,   0, 1, 44,  "R9");
    step(1, 0,   0, 1, 45,  "R9");
    step(1, 0,   0, 1, 468, "R9");
    step(1, 0,   0, 1, 467, "R9");
    // R1 reset restores defaults and reopens window
    do_reset();
    step(1, 0,  0, 1, 64,  "R1");
    step(1, 0,  0, 1, 65,  "R1");
    step(0, 12, 0, 1, 0,   "R1");
    step(1, 0,  0, 1, 12,  "R1");
    step(1, 0,  0, 1, 13,  "R1");
    repeat (3) @(negedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule